// File: doc/BRIEF.md
# Serial Tilt-Angle Pair Receiver

This block sits on a one-way asynchronous serial line driven by a sensor microcontroller. It rebuilds tilt-angle samples from that stream. Each sample arrives as two raw binary bytes with no separator between them. The first byte carries the whole degrees (0 to 255). The second byte carries the hundredths (0 to 99).

Byte recovery uses a framing state machine that steps through idle, start, data and stop phases. A fixed clocks-per-bit parameter sets the bit timing, and each bit is sampled at the middle of its period. A pairing stage after the framing receiver joins each whole-degree byte with the hundredths byte that follows it. It never merges halves that belong to adjacent samples. Two events put the pairing stage back into expecting a whole-degree byte: a broken stop bit, and a long silence on the line. The assembled angle is presented on two 8-bit outputs together with a one-cycle valid strobe.

Top module: `angle_pair_rx`

## Requirements
- R1: While reset (active-low `rstN`) is held and after it is released, `angleInt` and `angleFrac` read 0 and `angleValid` is low until the first pair has been received.
- R2: The line passes through a two-flop synchronizer. A frame begins on a falling edge seen while the receiver is idle. If the line is high again at the middle of the start bit, the event is treated as a glitch and rejected, and no byte results.
- R3: Each frame has eight data bits, least significant bit first, each `CLKS_PER_BIT` clocks wide and sampled at mid-bit.
- R4: The first good byte after realignment is taken as the integer part. The next good byte is the fractional part. After the stop bit of the fractional byte, `angleInt` shows the first byte and `angleFrac` shows the second.
- R5: `angleValid` is high for exactly one clock cycle for each assembled pair.
- R6: `angleInt` and `angleFrac` hold their values between valid strobes.
- R7: A frame whose stop bit is sampled low is dropped. The pairing stage then expects an integer byte, so any integer byte already held is discarded.
- R8: If the receiver stays idle for more than 20·`CLKS_PER_BIT` clocks (two byte times) while holding an integer byte, that byte is discarded and the next byte is taken as an integer. A shorter gap keeps the held byte.
- R9: Pairs sent back to back, with no idle time between frames, are assembled in order, each integer byte matched with its own fractional byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxLine | input | 1 | Asynchronous serial input, idle high |
| angleInt | output | 8 | Whole-degree part of the last assembled angle |
| angleFrac | output | 8 | Hundredths part of the last assembled angle |
| angleValid | output | 1 | One-cycle strobe marking a new angle |

## Verification
The bench goes after the ways a pairing stage can slip out of step. If a short low glitch were accepted as a frame, or a frame with a broken stop bit were kept, every later angle would pair a fractional byte with the next sample's integer byte. The bench checks that the angle sent after such an event comes out intact. It sends a lone integer byte and then waits once longer and once shorter than the silence limit. A design with a wrong limit either keeps the stale byte or drops a good one. Values with asymmetric bit patterns expose a reversed bit order. A pulse counter exposes extra or stretched valid strobes.

// File: rtl/angle_rx_pkg.sv
package angle_rx_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rxState_t;

  // Strobes from the control to the datapath, each at most one cycle wide
  typedef struct packed {
    logic sampleBit;  // mid-bit instant of a data bit
    logic byteDone;   // stop bit seen high, byte complete
    logic frameErr;   // stop bit seen low, byte rejected
    logic realign;    // idle limit reached, expect integer byte next
  } rxStrobe_t;

endpackage

// File: rtl/angle_rx_sync.sv
module angle_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '1;
    else       chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/angle_rx_ctrl.sv
module angle_rx_ctrl
  import angle_rx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int IDLE_BYTES   = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      lineIn,
  output rxStrobe_t stb
);

  localparam int CNT_W      = $clog2(CLKS_PER_BIT);
  localparam int HALF       = CLKS_PER_BIT / 2;
  localparam int IDLE_LIMIT = IDLE_BYTES * 10 * CLKS_PER_BIT;
  localparam int IDLE_W     = $clog2(IDLE_LIMIT + 2);
  localparam int LAST_BIT   = BYTE_W - 1;

  rxState_t             state;
  logic [CNT_W-1:0]     bitCnt;
  logic [2:0]           bitIdx;
  logic                 linePrev;
  logic [IDLE_W-1:0]    idleCnt;
  logic                 bitEnd;
  logic                 halfEnd;

  assign bitEnd  = (bitCnt == CNT_W'(CLKS_PER_BIT - 1));
  assign halfEnd = (bitCnt == CNT_W'(HALF - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= RX_IDLE;
      bitCnt   <= '0;
      bitIdx   <= '0;
      linePrev <= 1'b1;
    end else begin
      linePrev <= lineIn;
      case (state)
        RX_IDLE: begin
          bitCnt <= '0;
          if (linePrev && !lineIn) state <= RX_START;
        end
        RX_START: begin
          if (halfEnd) begin
            bitCnt <= '0;
            bitIdx <= '0;
            state  <= lineIn ? RX_IDLE : RX_DATA;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (bitEnd) begin
            bitCnt <= '0;
            bitIdx <= bitIdx + 1'b1;
            if (bitIdx == 3'(LAST_BIT)) state <= RX_STOP;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (bitEnd) begin
            bitCnt <= '0;
            state  <= RX_IDLE;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  // Idle time counter, saturating one past the limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if (state != RX_IDLE) begin
      idleCnt <= '0;
    end else if (idleCnt != IDLE_W'(IDLE_LIMIT + 1)) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  always_comb begin
    stb           = '0;
    stb.sampleBit = (state == RX_DATA) && bitEnd;
    stb.byteDone  = (state == RX_STOP) && bitEnd && lineIn;
    stb.frameErr  = (state == RX_STOP) && bitEnd && !lineIn;
    stb.realign   = (state == RX_IDLE) && (idleCnt == IDLE_W'(IDLE_LIMIT));
  end

endmodule

// File: rtl/angle_rx_dp.sv
module angle_rx_dp
  import angle_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineIn,
  input  rxStrobe_t         stb,
  output logic [BYTE_W-1:0] angleInt,
  output logic [BYTE_W-1:0] angleFrac,
  output logic              angleValid
);

  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] intHold;
  logic              haveInt;

  // Bits arrive LSB first: shift in from the top
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              shiftReg <= '0;
    else if (stb.sampleBit) shiftReg <= {lineIn, shiftReg[BYTE_W-1:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intHold    <= '0;
      haveInt    <= 1'b0;
      angleInt   <= '0;
      angleFrac  <= '0;
      angleValid <= 1'b0;
    end else begin
      angleValid <= 1'b0;
      if (stb.frameErr || stb.realign) begin
        haveInt <= 1'b0;
      end else if (stb.byteDone) begin
        if (!haveInt) begin
          intHold <= shiftReg;
          haveInt <= 1'b1;
        end else begin
          angleInt   <= intHold;
          angleFrac  <= shiftReg;
          angleValid <= 1'b1;
          haveInt    <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/angle_pair_rx.sv
module angle_pair_rx
  import angle_rx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int IDLE_BYTES   = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  output logic [BYTE_W-1:0] angleInt,
  output logic [BYTE_W-1:0] angleFrac,
  output logic              angleValid
);

  logic      lineSync;
  rxStrobe_t ctrlStb;

  angle_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (rxLine),
    .syncOut (lineSync)
  );

  angle_rx_ctrl #(
    .CLKS_PER_BIT (CLKS_PER_BIT),
    .IDLE_BYTES   (IDLE_BYTES)
  ) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .lineIn (lineSync),
    .stb    (ctrlStb)
  );

  angle_rx_dp i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .lineIn     (lineSync),
    .stb        (ctrlStb),
    .angleInt   (angleInt),
    .angleFrac  (angleFrac),
    .angleValid (angleValid)
  );

endmodule

// File: rtl/angle_pair_rx_chk.sv
module angle_pair_rx_chk
  import angle_rx_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [BYTE_W-1:0] angleInt,
  input logic [BYTE_W-1:0] angleFrac,
  input logic              angleValid,
  input rxStrobe_t         stb
);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    angleValid |=> !angleValid);

  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    !angleValid |-> ($stable(angleInt) && $stable(angleFrac)));

  a_r4_valid_after_byte: assert property (@(posedge clk) disable iff (!rstN)
    angleValid |-> $past(stb.byteDone));

  a_r7_stop_outcome_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.byteDone, stb.frameErr, stb.sampleBit}));

  a_r7_no_valid_after_err: assert property (@(posedge clk) disable iff (!rstN)
    stb.frameErr |=> !angleValid);

  a_r8_realign_only_idle: assert property (@(posedge clk) disable iff (!rstN)
    stb.realign |-> !(stb.byteDone || stb.frameErr || stb.sampleBit));

endmodule

bind angle_pair_rx angle_pair_rx_chk i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .angleInt   (angleInt),
  .angleFrac  (angleFrac),
  .angleValid (angleValid),
  .stb        (ctrlStb)
);

// File: tb/test_angle_pair_rx.sv
`timescale 1ns/1ps
module test_angle_pair_rx;

  localparam int CPB     = 16;
  localparam int IDLE_TO = 20 * CPB;
  localparam int NVEC    = 6;
  // each entry: {integer byte, fractional byte}
  localparam logic [15:0] VEC [NVEC] = '{
    16'h0000, 16'hFF63, 16'hA55A, 16'h0132, 16'h8001, 16'h7F10
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxLine = 1'b1;
  logic [7:0] angleInt, angleFrac;
  logic angleValid;

  int checks = 0, fails = 0;
  int pulses = 0, widthErr = 0;
  logic prevValid = 1'b0;
  logic [7:0] seenInt = '0, seenFrac = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  angle_pair_rx #(.CLKS_PER_BIT(CPB)) i_angle_pair_rx (
    .clk(clk), .rstN(rstN), .rxLine(rxLine),
    .angleInt(angleInt), .angleFrac(angleFrac), .angleValid(angleValid)
  );

  always @(negedge clk) begin
    if (angleValid) begin
      pulses++;
      seenInt  = angleInt;
      seenFrac = angleFrac;
      if (prevValid) widthErr++;
    end
    prevValid = angleValid;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input bit stopOk);
    @(negedge clk); rxLine = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxLine = b[i];
      repeat (CPB) @(negedge clk);
    end
    rxLine = stopOk;
    repeat (CPB) @(negedge clk);
    rxLine = 1'b1;
  endtask

  task automatic sendPair(input logic [7:0] hi, input logic [7:0] lo);
    sendByte(hi, 1'b1);
    sendByte(lo, 1'b1);
  endtask

  task automatic checkPair(input string req, input logic [7:0] ei,
                           input logic [7:0] ef, input int ePulses);
    repeat (4) @(negedge clk);
    check(req, seenInt, ei);
    check(req, seenFrac, ef);
    check(req, pulses, ePulses);
  endtask

  initial begin
    int expPulses = 0;
    repeat (5) @(negedge clk);
    // R1: reset state
    check("R1", angleInt, 0);
    check("R1", angleFrac, 0);
    check("R1", angleValid, 0);
    rstN = 1'b1;
    repeat (10) @(negedge clk);
    check("R1", angleValid, 0);

    // R3 R4 R9: table of pairs sent back to back
    for (int v = 0; v < NVEC; v++) begin
      sendPair(VEC[v][15:8], VEC[v][7:0]);
      expPulses++;
      checkPair("R4/R9", VEC[v][15:8], VEC[v][7:0], expPulses);
    end
    check("R3", angleInt, 8'h7F);

    // R6: outputs held with no traffic
    repeat (100) @(negedge clk);
    check("R6", angleInt, 8'h7F);
    check("R6", angleFrac, 8'h10);
    check("R6", pulses, expPulses);

    // R2: short low glitch rejected
    rxLine = 1'b0;
    repeat (3) @(negedge clk);
    rxLine = 1'b1;
    repeat (40) @(negedge clk);
    check("R2", pulses, expPulses);
    sendPair(8'h2C, 8'h05);
    expPulses++;
    checkPair("R2", 8'h2C, 8'h05, expPulses);

    // R7: bad stop bit drops the byte and clears the held integer
    sendByte(8'h11, 1'b1);
    sendByte(8'h22, 1'b0);
    repeat (20) @(negedge clk);
    check("R7", pulses, expPulses);
    sendPair(8'h33, 8'h44);
    expPulses++;
    checkPair("R7", 8'h33, 8'h44, expPulses);

    // R8: long silence discards a lone integer byte
    sendByte(8'h55, 1'b1);
    repeat (IDLE_TO + 80) @(negedge clk);
    sendPair(8'h66, 8'h07);
    expPulses++;
    checkPair("R8", 8'h66, 8'h07, expPulses);

    // R8: short silence keeps the held integer byte
    sendByte(8'h12, 1'b1);
    repeat (IDLE_TO - 120) @(negedge clk);
    sendByte(8'h34, 1'b1);
    expPulses++;
    checkPair("R8", 8'h12, 8'h34, expPulses);

    // R5: every strobe exactly one cycle wide
    check("R5", widthErr, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule